// File: doc/BRIEF.md
# Real-Time Clock with Shadowed Seconds and Alarms

A register-mapped real-time clock that counts milliseconds and 32-bit seconds from a slow tick of nominally 32.768 kHz, delivered as a one-cycle strobe on the bus clock. A fractional accumulator turns every 32768 ticks into exactly 1000 millisecond steps. The seconds counter advances whenever the millisecond counter wraps from 999 back to 0.

Software does not read the counters directly. It sees bus-side copies that are refreshed once every eight ticks. A status flag is high during the tick period just before each refresh, and counter loads are refused while that flag is high. Reading the millisecond copy also captures the bus-side seconds into a shadow register, so the two values can be read as a consistent pair.

Two seconds alarms and one millisecond alarm set bits in a status register that software clears by writing ones. A mask selects which status bits drive the level-high interrupt.

Top module: `rtcCore`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The millisecond value is floor(n*1000/32768) mod 1000, where n is the number of ticks since the last accepted seconds load. The seconds value is the loaded value plus floor(n*1000/32768)/1000.
- R3: Seconds (offset 0x008) and milliseconds (offset 0x010) read bus-side copies. These copies take the live counter values on every tick that makes n a multiple of 8, and hold their value between such ticks.
- R4: Bit 0 of offset 0x004 reads 1 exactly while n mod 8 equals 7, and reads 0 otherwise.
- R5: A read of offset 0x010 loads the bus-side seconds into the shadow register at offset 0x00C. The shadow register holds that value until the next millisecond read.
- R6: A write to offset 0x008 while busy is 0 loads the seconds counter and its copy, clears the millisecond counter, its copy, the accumulator and the tick phase, and restarts n at 0. The same write while busy is 1 changes nothing.
- R7: Seconds alarms at 0x014 and 0x018 set status bit 0 and bit 1 respectively on the tick where the seconds value changes to equal the alarm. The bit is not set again while the seconds value stays equal.
- R8: The millisecond alarm (bits 9:0 of 0x01C) sets status bit 2 on the tick where the millisecond value changes to equal it.
- R9: Writing 1 to a bit of the status register (0x02C) clears that bit, and writing 0 leaves it unchanged. Bits 3 and 4 always read 0. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: Status bits set whatever the mask (bits 4:0 of 0x028) holds. `irq` is 1 exactly when some status bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickIn | input | 1 | One-cycle strobe for each slow tick |
| busAddr | input | 8 | Byte offset of the register access |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (needed for the shadow capture) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from `busAddr` |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest state to reach is the end of a full second. The bench has to step through exactly 32768 ticks after a seconds load. At that point the seconds alarm fires, the bus-side seconds copy advances, and the shadow register must still hold the value captured by an earlier millisecond read. The bench counts ticks itself from each accepted load. It stops one tick short of the millisecond alarm and one tick short of a copy boundary, so the bus-side copy can be told apart from the live counter. It also issues a seconds load at n mod 8 = 7 to confirm the load is refused.

// File: rtl/rtcPkg.sv
package rtcPkg;
  localparam logic [7:0] ADDR_BUSY   = 8'h04;
  localparam logic [7:0] ADDR_SEC    = 8'h08;
  localparam logic [7:0] ADDR_SHADOW = 8'h0C;
  localparam logic [7:0] ADDR_MS     = 8'h10;
  localparam logic [7:0] ADDR_ALM0   = 8'h14;
  localparam logic [7:0] ADDR_ALM1   = 8'h18;
  localparam logic [7:0] ADDR_MSALM  = 8'h1C;
  localparam logic [7:0] ADDR_MASK   = 8'h28;
  localparam logic [7:0] ADDR_STAT   = 8'h2C;
  localparam int STAT_W    = 5;
  localparam int N_SEC_ALM = 2;

  typedef struct packed {
    logic                 msStep;
    logic                 copy;
    logic                 loadSec;
    logic [N_SEC_ALM-1:0] wrSecAlarm;
    logic                 wrMsAlarm;
    logic                 wrMask;
    logic                 wrStatus;
    logic                 capShadow;
  } rtcStrobeT;
endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtcPkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_TICKS    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickIn,
  input  logic [7:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  output rtcStrobeT  strobe,
  output logic       busy
);
  localparam int ACC_W = $clog2(TICKS_PER_SEC + MS_PER_SEC);
  localparam int PH_W  = (COPY_TICKS > 1) ? $clog2(COPY_TICKS) : 1;
  localparam logic [ACC_W-1:0] TICKS_C = ACC_W'(TICKS_PER_SEC);
  localparam logic [ACC_W-1:0] MS_C    = ACC_W'(MS_PER_SEC);
  localparam logic [PH_W-1:0]  LAST_PH = PH_W'(COPY_TICKS - 1);

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic [PH_W-1:0]  phase;
  logic             loadOk;

  assign accSum = acc + MS_C;
  assign busy   = (phase == LAST_PH);
  assign loadOk = busWr && (busAddr == ADDR_SEC) && !busy;

  always_comb begin
    strobe              = '0;
    strobe.msStep       = tickIn && (accSum >= TICKS_C) && !loadOk;
    strobe.copy         = tickIn && busy;
    strobe.loadSec      = loadOk;
    strobe.wrSecAlarm[0] = busWr && (busAddr == ADDR_ALM0);
    strobe.wrSecAlarm[1] = busWr && (busAddr == ADDR_ALM1);
    strobe.wrMsAlarm    = busWr && (busAddr == ADDR_MSALM);
    strobe.wrMask       = busWr && (busAddr == ADDR_MASK);
    strobe.wrStatus     = busWr && (busAddr == ADDR_STAT);
    strobe.capShadow    = busRd && (busAddr == ADDR_MS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      phase <= '0;
    end else if (loadOk) begin
      acc   <= '0;
      phase <= '0;
    end else if (tickIn) begin
      acc   <= (accSum >= TICKS_C) ? accSum - TICKS_C : accSum;
      phase <= busy ? '0 : phase + 1'b1;
    end
  end

  // The busy window closes on the tick that performs the copy.
  assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rstN)
    tickIn && busy |=> !busy);
  // Busy opens only as the result of a tick.
  assert_busy_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(tickIn));
  // A seconds load during busy leaves the window in place.
  assert_load_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && (busAddr == ADDR_SEC) && busy && !tickIn |=> busy);
endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtcPkg::*;
#(
  parameter int MS_PER_SEC = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  rtcStrobeT   strobe,
  input  logic        busy,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  localparam int MS_W = $clog2(MS_PER_SEC);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic [31:0]       secCnt, secBus, shadowSec, secNext;
  logic [MS_W-1:0]   msCnt, msBus, msNext, msAlarm;
  logic [31:0]       secAlarm [N_SEC_ALM];
  logic [STAT_W-1:0] mask, status, setVec, clrVec;
  logic              msWrap, secStep;

  assign msWrap  = strobe.msStep && (msCnt == MS_LAST);
  assign msNext  = !strobe.msStep ? msCnt : (msWrap ? '0 : msCnt + 1'b1);
  assign secStep = msWrap;
  assign secNext = secCnt + {31'd0, secStep};

  genvar g;
  generate
    for (g = 0; g < N_SEC_ALM; g++) begin : genSecAlarm
      always_ff @(posedge clk) begin
        if (!rstN)                     secAlarm[g] <= '0;
        else if (strobe.wrSecAlarm[g]) secAlarm[g] <= busWdata;
      end
      assign setVec[g] = secStep && (secNext == secAlarm[g]);
    end
  endgenerate

  assign setVec[2]          = strobe.msStep && (msNext == msAlarm);
  assign setVec[STAT_W-1:3] = '0;
  assign clrVec = strobe.wrStatus ? busWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt <= '0; msCnt <= '0; secBus <= '0; msBus <= '0;
      shadowSec <= '0; msAlarm <= '0; mask <= '0; status <= '0;
    end else begin
      if (strobe.loadSec) begin
        secCnt <= busWdata; msCnt <= '0;
        secBus <= busWdata; msBus <= '0;
      end else begin
        secCnt <= secNext; msCnt <= msNext;
        if (strobe.copy) begin
          secBus <= secNext; msBus <= msNext;
        end
      end
      if (strobe.capShadow) shadowSec <= secBus;
      if (strobe.wrMsAlarm) msAlarm <= busWdata[MS_W-1:0];
      if (strobe.wrMask)    mask    <= busWdata[STAT_W-1:0];
      status <= (status & ~clrVec) | setVec;
    end
  end

  assign irq = |(status & mask);

  always_comb begin
    case (busAddr)
      ADDR_BUSY:   busRdata = {31'd0, busy};
      ADDR_SEC:    busRdata = secBus;
      ADDR_SHADOW: busRdata = shadowSec;
      ADDR_MS:     busRdata = {{(32-MS_W){1'b0}}, msBus};
      ADDR_ALM0:   busRdata = secAlarm[0];
      ADDR_ALM1:   busRdata = secAlarm[1];
      ADDR_MSALM:  busRdata = {{(32-MS_W){1'b0}}, msAlarm};
      ADDR_MASK:   busRdata = {{(32-STAT_W){1'b0}}, mask};
      ADDR_STAT:   busRdata = {{(32-STAT_W){1'b0}}, status};
      default:     busRdata = '0;
    endcase
  end

  assert_ms_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    msCnt <= MS_LAST);
  assert_alarm_on_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[0]) |-> secCnt != $past(secCnt));
  assert_countdown_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    status[STAT_W-1:3] == '0);
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStatus && busWdata[1] && !setVec[1] |=> !status[1]);
  assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capShadow |=> $stable(shadowSec));
endmodule

// File: rtl/rtcCore.sv
module rtcCore
  import rtcPkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int MS_PER_SEC    = 1000,
  parameter int COPY_TICKS    = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickIn,
  input  logic [7:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq
);
  rtcStrobeT strobe;
  logic      busy;

  rtcCtrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .MS_PER_SEC(MS_PER_SEC), .COPY_TICKS(COPY_TICKS)
  ) i_rtcCtrl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .strobe(strobe), .busy(busy)
  );

  rtcDatapath #(.MS_PER_SEC(MS_PER_SEC)) i_rtcDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );
endmodule

// File: tb/test_rtcCore.sv
`timescale 1ns/1ps
module test_rtcCore;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  longint nTicks = 0;
  longint secBase = 0;

  always #2.5 clk = ~clk;

  rtcCore i_rtcCore (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  function automatic longint totMs(longint n);
    return (n / 8 * 8) * 1000 / 32768;
  endfunction

  task automatic check(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output longint v);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 v = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic doTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1'b1;
      @(negedge clk); tickIn = 1'b0;
      nTicks++;
    end
  endtask

  task automatic loadSec(longint s);
    busWrite(8'h08, 32'(s));
    secBase = s; nTicks = 0;
  endtask

  task automatic testReset();
    longint v;
    busRead(8'h04, v); check("R1 busy", v, 0);
    busRead(8'h08, v); check("R1 seconds", v, 0);
    busRead(8'h10, v); check("R1 ms", v, 0);
    busRead(8'h2C, v); check("R1 status", v, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic testCopyAndBusy();
    longint v;
    loadSec(100);
    doTicks(199);
    busRead(8'h04, v); check("R4 busy at n%8==7", v, 1);
    busRead(8'h10, v); check("R3 ms copy held", v, totMs(199));
    busRead(8'h08, v); check("R3 seconds copy", v, 100);
    doTicks(1);
    busRead(8'h04, v); check("R4 busy cleared", v, 0);
    busRead(8'h10, v); check("R2 ms after 200 ticks", v, 6);
  endtask

  task automatic testBusyWrite();
    longint v;
    doTicks(7);
    busRead(8'h04, v); check("R4 busy again", v, 1);
    busWrite(8'h08, 32'd5);
    busRead(8'h08, v); check("R6 load ignored when busy", v, 100);
    doTicks(1);
    busRead(8'h10, v); check("R6 ms continues", v, totMs(nTicks) % 1000);
    loadSec(7);
    busRead(8'h08, v); check("R6 load accepted", v, 7);
    busRead(8'h10, v); check("R6 ms cleared", v, 0);
    busRead(8'h04, v); check("R6 phase cleared", v, 0);
  endtask

  task automatic testMsAlarm();
    longint v;
    busWrite(8'h1C, 32'd500);
    busWrite(8'h14, 32'd201);
    busWrite(8'h18, 32'd300);
    busWrite(8'h28, 32'd0);
    loadSec(200);
    doTicks(16383);
    busRead(8'h2C, v); check("R8 status before ms alarm", v, 0);
    doTicks(1);
    busRead(8'h2C, v); check("R8 ms alarm status", v, 4);
    check("R10 masked irq", irq, 0);
    busWrite(8'h28, 32'd4);
    #1 check("R10 irq with mask", irq, 1);
    busWrite(8'h2C, 32'd0);
    busRead(8'h2C, v); check("R9 write 0 keeps", v, 4);
    busWrite(8'h2C, 32'h1C);
    busRead(8'h2C, v); check("R9 write 1 clears", v, 0);
    check("R10 irq cleared", irq, 0);
  endtask

  task automatic testSecAlarmShadow();
    longint v;
    busRead(8'h10, v); check("R2 ms at half second", v, 500);
    busRead(8'h0C, v); check("R5 shadow captured", v, 200);
    doTicks(16384);
    busRead(8'h08, v); check("R2 seconds wrap", v, secBase + totMs(nTicks) / 1000);
    busRead(8'h0C, v); check("R5 shadow held", v, 200);
    busRead(8'h2C, v); check("R7 seconds alarm 0", v, 1);
    busRead(8'h10, v); check("R2 ms wrapped", v, 0);
    busRead(8'h0C, v); check("R5 shadow updated", v, 201);
    busWrite(8'h28, 32'd1);
    #1 check("R10 irq from alarm 0", irq, 1);
    busWrite(8'h2C, 32'd1);
    doTicks(64);
    busRead(8'h2C, v); check("R7 no re-set while equal", v, 0);
    busRead(8'h08, v); check("R7 seconds still equal", v, 201);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testCopyAndBusy();
    testBusyWrite();
    testMsAlarm();
    testSecAlarmShadow();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule